// File: doc/BRIEF.md
# Remote Mailbox Signal Register

This block is a small write-only slave that sits on a 16-bit short I/O address space shared by several processors. Another processor interrupts the local CPU by writing to one address. That address is built from an 8-bit group byte, the local 4-bit processor number and a fixed low nibble of 2. The low four data bits of the write are ORed into a bank of four sticky signal flags.

The local side controls each flag with its own enable bit. The interrupt line stays asserted while any flag is both set and enabled. Local software acknowledges a flag by writing a one-hot or multi-bit mask to a write-one-to-clear port. A remote processor can only set flags, and the local side can only clear them. When both act on the same bit in the same cycle, the set takes priority, so a fresh remote signal is never lost.

Top module: `mbx_signal_reg`

## Requirements
- R1: While `rst` is high at a clock edge, `sig_bits`, `en_bits` and `irq` become 0 after that edge.
- R2: A remote write is decoded only when `rmt_addr` equals `{grp_byte, proc_num, 4'h2}`. For example, group 0xC2 with processor 0 decodes 0xC202, and with processor 1 it decodes 0xC212. A write to any other address leaves `sig_bits` unchanged.
- R3: A remote write is accepted only when `rmt_am` is 6'h2D (supervisor short I/O). A write with any other modifier leaves `sig_bits` unchanged.
- R4: An accepted remote write ORs `rmt_wdata[3:0]` into `sig_bits`, with bit i setting flag i. The result is visible after the next clock edge. `rmt_wdata[7:4]` has no effect, and a remote write never clears a flag.
- R5: When `loc_clr_we` is high, each flag whose bit in `loc_clr_mask` is 1 is cleared at the next edge. Flags whose mask bit is 0 keep their value.
- R6: If a local clear and an accepted remote set target the same flag in the same cycle, that flag is 1 after the edge.
- R7: When `loc_en_we` is high, `en_bits` takes the value of `loc_en_data` at the next edge. Otherwise it holds its value.
- R8: `irq` is a registered level that equals the OR of (`sig_bits` AND `en_bits`) in every cycle after reset. It changes on the same edge as the flags and enables that drive it.
- R9: A remote write of data 0x08 to the decoded address sets flag 3 (`sig_bits` = 4'b1000 when starting from zero). With `en_bits[3]` set, this raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_byte | input | 8 | Group byte, the upper address byte |
| proc_num | input | 4 | Local processor number, address bits 7:4 |
| rmt_strobe | input | 1 | Remote write valid for one cycle |
| rmt_addr | input | 16 | Remote short I/O address |
| rmt_am | input | 6 | Remote address modifier |
| rmt_wdata | input | 8 | Remote write data |
| loc_clr_we | input | 1 | Local write-one-to-clear strobe |
| loc_clr_mask | input | 4 | Flags to clear |
| loc_en_we | input | 1 | Local enable register write strobe |
| loc_en_data | input | 4 | New enable value |
| sig_bits | output | 4 | Signal flags |
| en_bits | output | 4 | Per-flag interrupt enables |
| irq | output | 1 | Level interrupt to the local CPU |

## Verification
Every stored bit of this block is visible at its ports, so a wrong flag or enable bit shows on `sig_bits` or `en_bits` at the first negative edge after the faulty clock edge. A mismatch in interrupt gating shows on `irq` in the same cycle. The risky cases are decode aliasing on a neighbouring processor number, a modifier that is accepted when it should not be, and a clear that wins over a simultaneous set. Each of these leaves a flag wrong for one cycle or longer, and the per-cycle comparison against the model catches it there.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int SIG_W   = 4;
  localparam int ADDR_W  = 16;
  localparam int GRP_W   = 8;
  localparam int PROC_W  = 4;
  localparam int AM_W    = 6;
  localparam int DATA_W  = 8;
  localparam logic [AM_W-1:0] AM_SUP_SHORT = 6'h2D;
  localparam int OFF_W   = ADDR_W - GRP_W - PROC_W;
  localparam logic [OFF_W-1:0] REG_OFFSET = OFF_W'(2);
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W,
  parameter int GRP_W_P  = GRP_W,
  parameter int PROC_W_P = PROC_W,
  parameter int AM_W_P   = AM_W,
  parameter logic [AM_W_P-1:0] AM_OK = AM_SUP_SHORT
) (
  input  logic                  strobe,
  input  logic [ADDR_W_P-1:0]   addr,
  input  logic [AM_W_P-1:0]     am,
  input  logic [GRP_W_P-1:0]    grp,
  input  logic [PROC_W_P-1:0]   proc,
  output logic                  hit
);
  localparam int LOW_W = ADDR_W_P - GRP_W_P - PROC_W_P;
  localparam logic [LOW_W-1:0] LOW_VAL = LOW_W'(2);

  logic [ADDR_W_P-1:0] base;
  always_comb begin
    base = {grp, proc, LOW_VAL};
    hit  = strobe && (am == AM_OK) && (addr == base);
  end
endmodule

// File: rtl/mbx_sig_bank.sv
module mbx_sig_bank
  import mbx_pkg::*;
#(
  parameter int N = SIG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_v,
  input  logic [N-1:0] set_data,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic         en_we,
  input  logic [N-1:0] en_data,
  output logic [N-1:0] sig_q,
  output logic [N-1:0] sig_d,
  output logic [N-1:0] en_q,
  output logic [N-1:0] en_d
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic kill, make;
    always_comb begin
      kill     = clr_we & clr_mask[i];
      make     = set_v & set_data[i];
      sig_d[i] = (sig_q[i] & ~kill) | make;
      en_d[i]  = en_we ? en_data[i] : en_q[i];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        sig_q[i] <= 1'b0;
        en_q[i]  <= 1'b0;
      end else begin
        sig_q[i] <= sig_d[i];
        en_q[i]  <= en_d[i];
      end
    end
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen
  import mbx_pkg::*;
#(
  parameter int N = SIG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_nxt,
  input  logic [N-1:0] en_nxt,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sig_nxt & en_nxt);
  end
endmodule

// File: rtl/mbx_signal_reg.sv
module mbx_signal_reg
  import mbx_pkg::*;
#(
  parameter int SIG_W_P  = SIG_W,
  parameter int ADDR_W_P = ADDR_W,
  parameter int GRP_W_P  = GRP_W,
  parameter int PROC_W_P = PROC_W,
  parameter int AM_W_P   = AM_W,
  parameter int DATA_W_P = DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [GRP_W_P-1:0]  grp_byte,
  input  logic [PROC_W_P-1:0] proc_num,
  input  logic                rmt_strobe,
  input  logic [ADDR_W_P-1:0] rmt_addr,
  input  logic [AM_W_P-1:0]   rmt_am,
  input  logic [DATA_W_P-1:0] rmt_wdata,
  input  logic                loc_clr_we,
  input  logic [SIG_W_P-1:0]  loc_clr_mask,
  input  logic                loc_en_we,
  input  logic [SIG_W_P-1:0]  loc_en_data,
  output logic [SIG_W_P-1:0]  sig_bits,
  output logic [SIG_W_P-1:0]  en_bits,
  output logic                irq
);
  logic               hit;
  logic [SIG_W_P-1:0] sig_nxt, en_nxt;

  mbx_addr_dec #(
    .ADDR_W_P(ADDR_W_P), .GRP_W_P(GRP_W_P),
    .PROC_W_P(PROC_W_P), .AM_W_P(AM_W_P)
  ) u_dec (
    .strobe(rmt_strobe), .addr(rmt_addr), .am(rmt_am),
    .grp(grp_byte), .proc(proc_num), .hit(hit)
  );

  mbx_sig_bank #(.N(SIG_W_P)) u_bank (
    .clk(clk), .rst(rst),
    .set_v(hit), .set_data(rmt_wdata[SIG_W_P-1:0]),
    .clr_we(loc_clr_we), .clr_mask(loc_clr_mask),
    .en_we(loc_en_we), .en_data(loc_en_data),
    .sig_q(sig_bits), .sig_d(sig_nxt),
    .en_q(en_bits), .en_d(en_nxt)
  );

  mbx_irq_gen #(.N(SIG_W_P)) u_irq (
    .clk(clk), .rst(rst),
    .sig_nxt(sig_nxt), .en_nxt(en_nxt), .irq_q(irq)
  );
endmodule

// File: rtl/mbx_signal_chk.sv
module mbx_signal_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  grp_byte,
  input logic [3:0]  proc_num,
  input logic        rmt_strobe,
  input logic [15:0] rmt_addr,
  input logic [5:0]  rmt_am,
  input logic [7:0]  rmt_wdata,
  input logic        loc_clr_we,
  input logic [3:0]  loc_clr_mask,
  input logic        loc_en_we,
  input logic [3:0]  loc_en_data,
  input logic [3:0]  sig_bits,
  input logic [3:0]  en_bits,
  input logic        irq
);
  logic at_me;
  assign at_me = (rmt_addr == {grp_byte, proc_num, 4'h2});

  // R3
  bad_am_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (rmt_strobe && rmt_am != 6'h2D && !loc_clr_we) |=> $stable(sig_bits));

  // R2
  wrong_addr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (rmt_strobe && !at_me && !loc_clr_we) |=> $stable(sig_bits));

  // R4
  remote_never_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !loc_clr_we |=> ((sig_bits & $past(sig_bits)) == $past(sig_bits)));

  // R6
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (rmt_strobe && at_me && rmt_am == 6'h2D)
      |=> ((sig_bits & $past(rmt_wdata[3:0])) == $past(rmt_wdata[3:0])));

  // R5
  clear_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (loc_clr_we && !rmt_strobe) |=> ((sig_bits & $past(loc_clr_mask)) == 4'h0));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq == |(sig_bits & en_bits)));
endmodule

bind mbx_signal_reg mbx_signal_chk u_chk (.*);

// File: tb/tb_mbx_signal_reg.sv
module tb_mbx_signal_reg;
  logic clk = 1'b0;
  logic rst;
  logic [7:0]  grp_byte;
  logic [3:0]  proc_num;
  logic        rmt_strobe;
  logic [15:0] rmt_addr;
  logic [5:0]  rmt_am;
  logic [7:0]  rmt_wdata;
  logic        loc_clr_we;
  logic [3:0]  loc_clr_mask;
  logic        loc_en_we;
  logic [3:0]  loc_en_data;
  logic [3:0]  sig_bits, en_bits;
  logic        irq;

  always #2 clk = ~clk;

  mbx_signal_reg dut (.*);

  int vectors = 0, errors = 0;
  string tag = "R1";
  bit [3:0] m_sig, m_en;
  bit m_irq;

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit hit;
    @(posedge clk);
    hit = rmt_strobe && rmt_am == 6'h2D &&
          rmt_addr[15:8] == grp_byte && rmt_addr[7:4] == proc_num &&
          rmt_addr[3:0] == 4'h2;
    if (rst) begin
      m_sig = 0; m_en = 0;
    end else begin
      if (loc_clr_we) m_sig = m_sig & ~loc_clr_mask;
      if (hit) m_sig = m_sig | rmt_wdata[3:0];
      if (loc_en_we) m_en = loc_en_data;
    end
    m_irq = (m_sig & m_en) != 0;
    @(negedge clk);
    cmp("sig_bits", sig_bits, m_sig);
    cmp("en_bits", en_bits, m_en);
    cmp("irq", irq, m_irq);
  endtask

  task automatic idle();
    rmt_strobe = 0; loc_clr_we = 0; loc_en_we = 0;
  endtask

  task automatic rwrite(logic [15:0] a, logic [5:0] am, logic [7:0] d);
    idle(); rmt_strobe = 1; rmt_addr = a; rmt_am = am; rmt_wdata = d;
    tick(); idle();
  endtask

  task automatic lclear(logic [3:0] m);
    idle(); loc_clr_we = 1; loc_clr_mask = m; tick(); idle();
  endtask

  task automatic len(logic [3:0] e);
    idle(); loc_en_we = 1; loc_en_data = e; tick(); idle();
  endtask

  bit done = 0;
  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    rst = 1; grp_byte = 8'hC2; proc_num = 4'h0;
    rmt_addr = 0; rmt_am = 0; rmt_wdata = 0; loc_clr_mask = 0; loc_en_data = 0;
    idle();
    @(negedge clk);
    tag = "R1"; tick(); tick();
    rst = 0;
    tag = "R7"; len(4'b1000);
    tag = "R9"; rwrite(16'hC202, 6'h2D, 8'h08);
    tag = "R9"; cmp("sig_bits_direct", sig_bits, 4'h8); cmp("irq_direct", irq, 1);
    tag = "R5"; lclear(4'b1000);
    tag = "R3"; rwrite(16'hC202, 6'h29, 8'h0F);
    tag = "R3"; rwrite(16'hC202, 6'h3D, 8'h0F);
    tag = "R2"; rwrite(16'hC212, 6'h2D, 8'h0F);
    tag = "R2"; rwrite(16'hC203, 6'h2D, 8'h0F);
    tag = "R2"; rwrite(16'hC302, 6'h2D, 8'h0F);
    tag = "R2"; proc_num = 4'h1; rwrite(16'hC212, 6'h2D, 8'h02);
    tag = "R4"; rwrite(16'hC212, 6'h2D, 8'hF1);
    tag = "R4"; rwrite(16'hC212, 6'h2D, 8'h00);
    tag = "R8"; len(4'b0100); len(4'b0011);
    tag = "R5"; lclear(4'b0001);
    tag = "R6"; idle(); rmt_strobe = 1; rmt_addr = 16'hC212; rmt_am = 6'h2D;
    rmt_wdata = 8'h02; loc_clr_we = 1; loc_clr_mask = 4'hF; tick(); idle();
    tag = "R6"; cmp("sig_bits_collide", sig_bits, 4'h2);
    tag = "R1"; rst = 1; rwrite(16'hC212, 6'h2D, 8'h0F); rst = 0;
    tag = "R8";
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rmt_strobe = lfsr[0];
      rmt_addr = lfsr[1] ? {grp_byte, proc_num, 4'h2} : {grp_byte, lfsr[5:2], 4'h2};
      rmt_am = lfsr[6] ? 6'h2D : 6'h29;
      rmt_wdata = lfsr[15:8];
      loc_clr_we = lfsr[7] & lfsr[3];
      loc_clr_mask = lfsr[11:8];
      loc_en_we = lfsr[12] & lfsr[14];
      loc_en_data = lfsr[7:4];
      tick();
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule